// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address for each beat of a four-beat burst access. A start address is captured whenever either of two active-low address strobes is asserted; from then on, every clock edge that sees the advance input asserted while both strobes are idle steps the burst to its next beat. Only the low two address bits move. The upper bits of the captured address stay as they are for the whole burst, and the sequence wraps inside its aligned four-beat block.

Two beat orders are supported. The interleaved order forms each beat by XOR-ing the beat number into the starting low bits. The linear order adds the beat number modulo four. The order input is sampled together with the start address, so each burst keeps one order from start to end. At board level this input is meant to be tied high when unused, which selects the interleaved order. A last-beat flag is high while the fourth address of the sequence is on the output.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `burst_addr` is 0 and `last_beat` is 0.
- R2: A low level on `proc_strobe_n` or `ctrl_strobe_n` at a rising edge loads `start_addr`. From the next cycle `burst_addr` equals `start_addr` (beat 0).
- R3: A load overrides an advance requested on the same edge, so the output shows beat 0 of the new start address.
- R4: The burst moves one beat only at an edge where `advance_n` is 0 and both strobes are 1. At any other edge with no load, `burst_addr` holds its value.
- R5: With `order_sel` = 1 at load, the low two bits of beat n equal the starting low bits XOR n.
- R6: With `order_sel` = 0 at load, the low two bits of beat n equal the starting low bits plus n, modulo 4.
- R7: An advance from the fourth beat returns the output to the start address, and bits above bit 1 never change between loads.
- R8: `last_beat` is 1 exactly while the fourth beat (n = 3) is presented, and 0 otherwise.
- R9: Changing `order_sel` after a load has no effect on the burst in progress. The new value only applies from the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_addr | input | ADDR_W | Burst start address, sampled on a load |
| proc_strobe_n | input | 1 | First address strobe, active low |
| ctrl_strobe_n | input | 1 | Second address strobe, active low |
| advance_n | input | 1 | Advance request, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| burst_addr | output | ADDR_W | Current burst address |
| last_beat | output | 1 | High while the fourth beat is presented |

## Verification
Every result is registered one stage deep. A load or an advance sampled at edge k shows on `burst_addr` and `last_beat` right after edge k, and the outputs then hold until the next qualifying edge. The bench changes its inputs one time unit after a rising edge and compares the outputs one time unit after the following rising edge, so each comparison sees the state that exactly one edge has produced. Every start value is run in both orders through six beats, which covers the wrap and the flag on the fourth beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

    logic [BEAT_W-1:0] beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (load)
            beat_d = '0;
        else if (step)
            beat_d = beat_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign beat = beat_q;
    assign last = (beat_q == LAST_BEAT);

    // A load always restarts the beat count (R3)
    p_load_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat == '0));

    // Without a load or a step the count is frozen (R4)
    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(beat));
endmodule

// File: rtl/order_map.sv
module order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_low,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    assign lin_low = base_low + beat;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = base_low[b] ^ beat[b];
    end

    always_comb begin
        low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
        // Beat 0 must always be the start address itself (R2)
        if (beat == '0) assert (low == base_low);
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              last_beat
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        burst_order_e      order;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    logic              load, step;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;

    assign load = !proc_strobe_n || !ctrl_strobe_n;
    assign step = !advance_n && proc_strobe_n && ctrl_strobe_n;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base  = start_addr;
            st_d.order = order_sel ? ORD_INTERLEAVE : ORD_LINEAR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.order <= ORD_INTERLEAVE;
        end else begin
            st_q <= st_d;
        end
    end

    beat_counter #(.BEAT_W(BEAT_W)) i_beat_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .beat  (beat),
        .last  (last_beat)
    );

    order_map #(.BEAT_W(BEAT_W)) i_order_map (
        .base_low (st_q.base[BEAT_W-1:0]),
        .beat     (beat),
        .order    (st_q.order),
        .low      (low)
    );

    assign burst_addr = {st_q.base[ADDR_W-1:BEAT_W], low};

    // The loaded start address appears one edge later (R2)
    p_load_shows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (burst_addr == $past(start_addr)));

    // No load and no step: the address holds (R4)
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(burst_addr));

    // Upper bits never move without a load (R7)
    p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(burst_addr[ADDR_W-1:BEAT_W]));

    // Stepping past the last beat lands back on the start address (R7)
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && step && !load) |=> (burst_addr == st_q.base && !last_beat));

    // The flag persists while the address is held (R8)
    p_last_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !step && !load) |=> last_beat);

    if (UPPER_W < 1) begin : g_bad_width
        initial assert (0) else $error("ADDR_W must exceed BEAT_W");
    end
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 17;
    localparam logic [ADDR_W-3:0] UPPER = 15'h5A3C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              proc_strobe_n = 1'b1;
    logic              ctrl_strobe_n = 1'b1;
    logic              advance_n = 1'b1;
    logic              order_sel = 1'b1;
    logic [ADDR_W-1:0] burst_addr;
    logic              last_beat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) i_burst_addr_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_addr    (start_addr),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .order_sel     (order_sel),
        .burst_addr    (burst_addr),
        .last_beat     (last_beat)
    );

    function automatic logic [1:0] ref_low(logic [1:0] s, int n, bit ilv);
        logic [1:0] nn = 2'(n % 4);
        return ilv ? (s ^ nn) : (s + nn);
    endfunction

    task automatic chk(string req, logic [ADDR_W-1:0] got, logic [ADDR_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step_clk();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) step_clk();
        chk("R1 addr in reset", burst_addr, '0);
        chk("R1 flag in reset", {16'b0, last_beat}, '0);
        rst_n = 1'b1;
        step_clk();
        chk("R1 addr after reset", burst_addr, '0);
        chk("R1 flag after reset", {16'b0, last_beat}, '0);
    endtask

    task automatic t_sweep();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                start_addr = {UPPER, 2'(s)};
                order_sel  = m[0];
                if (s[0]) ctrl_strobe_n = 1'b0; else proc_strobe_n = 1'b0;
                step_clk();
                proc_strobe_n = 1'b1;
                ctrl_strobe_n = 1'b1;
                chk("R2 beat0", burst_addr, start_addr);
                advance_n = 1'b0;
                for (int n = 1; n < 6; n++) begin
                    step_clk();
                    chk(m[0] ? "R5 interleaved beat" : "R6 linear beat",
                        burst_addr, {UPPER, ref_low(2'(s), n, m[0])});
                    chk("R8 last flag", {16'b0, last_beat}, {16'b0, (n % 4) == 3});
                    if (n == 4) chk("R7 wrap to start", burst_addr, start_addr);
                end
                advance_n = 1'b1;
            end
        end
    endtask

    task automatic t_hold();
        start_addr = {UPPER, 2'b10};
        order_sel = 1'b0;
        proc_strobe_n = 1'b0;
        step_clk();
        proc_strobe_n = 1'b1;
        advance_n = 1'b0;
        step_clk();
        step_clk();
        step_clk();
        advance_n = 1'b1;
        chk("R8 flag on beat 3", {16'b0, last_beat}, 17'd1);
        for (int k = 0; k < 3; k++) begin
            step_clk();
            chk("R4 hold without advance", burst_addr, {UPPER, 2'b01});
            chk("R8 flag held", {16'b0, last_beat}, 17'd1);
        end
    endtask

    task automatic t_priority();
        start_addr = {UPPER, 2'b00};
        order_sel = 1'b1;
        ctrl_strobe_n = 1'b0;
        step_clk();
        ctrl_strobe_n = 1'b1;
        advance_n = 1'b0;
        step_clk();
        chk("R4 advance step", burst_addr, {UPPER, 2'b01});
        start_addr = {~UPPER, 2'b11};
        proc_strobe_n = 1'b0;
        step_clk();
        chk("R3 load over advance", burst_addr, {~UPPER, 2'b11});
        chk("R3 flag cleared", {16'b0, last_beat}, '0);
        proc_strobe_n = 1'b1;
        ctrl_strobe_n = 1'b0;
        start_addr = {UPPER, 2'b10};
        step_clk();
        chk("R2 second strobe with advance", burst_addr, {UPPER, 2'b10});
        ctrl_strobe_n = 1'b1;
        advance_n = 1'b1;
    endtask

    task automatic t_order_latch();
        start_addr = {UPPER, 2'b01};
        order_sel = 1'b1;
        proc_strobe_n = 1'b0;
        step_clk();
        proc_strobe_n = 1'b1;
        order_sel = 1'b0;
        advance_n = 1'b0;
        step_clk();
        chk("R9 order kept after change", burst_addr, {UPPER, 2'b00});
        step_clk();
        chk("R9 order kept beat2", burst_addr, {UPPER, 2'b11});
        advance_n = 1'b1;
        proc_strobe_n = 1'b0;
        step_clk();
        proc_strobe_n = 1'b1;
        advance_n = 1'b0;
        step_clk();
        chk("R9 new order after load", burst_addr, {UPPER, 2'b10});
        advance_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sweep();
        t_hold();
        t_priority();
        t_order_latch();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule